// File: doc/BRIEF.md
# Priority-Ordered Test-Bus Bandwidth Allocator

This block shares a fixed amount of test-bus bandwidth among several cores. Each core waiting for test reports whether it is ready, how many patterns it still has to apply, a weight for its chance of being defective, its current temperature and the bandwidth it needs. When the scheduler pulses the allocate strobe, the block opens a round. In each round it takes the waiting cores, highest priority first, and grants bandwidth to them one per cycle. It keeps a ledger so that the granted total never goes above the configured limit.

Priority rises with the remaining pattern count and with the defect weight, and falls with temperature. A core with many patterns left, a high defect likelihood and a low temperature is therefore served first. The quotient is never formed. Two candidates are ranked by cross-multiplying each one's pattern-weight product with the other's temperature.

A round ends at the first candidate that does not fit. It also ends when free bandwidth reaches zero or when no candidates remain. A core that stops testing pulses its release line, and the amount it was granted flows back into the free pool.

Top module: `bw_grant_alloc`

## Requirements
- R1: After reset, `free_bw` equals `bw_limit`, `busy` is low, `grant` is all zeros and no core holds bandwidth.
- R2: A round considers only the cores that are ready and not holding bandwidth at the cycle the strobe is accepted. A core that already holds bandwidth, or was not ready, is never granted in that round.
- R3: Candidates are granted in decreasing order of (remaining patterns × defect weight) / temperature. Core a ranks above core b when keyA × tempB > keyB × tempA. On equality the lower core index ranks first.
- R4: A candidate is granted when its required bandwidth is less than or equal to `free_bw`. One cycle after the grant pulse, `free_bw` is lower by exactly that requirement.
- R5: When the highest-ranked remaining candidate needs more than `free_bw`, the round ends without a grant. No lower-ranked candidate is granted in that round, even one that would fit.
- R6: `busy` rises in the cycle after an accepted strobe. It stays high for exactly one cycle per grant plus one closing cycle. The round closes when candidates run out, when free bandwidth is zero, or on a misfit.
- R7: `free_bw` never exceeds `bw_limit`, so the bandwidth held by granted cores never exceeds the limit.
- R8: Pulsing `core_stop[i]` for a core that holds bandwidth returns the amount captured at its grant, and `free_bw` reflects it one cycle later. A later change of that core's `req_bw` does not alter the amount returned. `core_stop` for a core holding nothing leaves `free_bw` unchanged.
- R9: An `alloc_go` pulse while `busy` is high is ignored: it neither extends the round nor opens another one.
- R10: `grant` is one-hot or zero in every cycle. Bit i of `grant` is the pulse for core i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ready | input | N_CORES | Core i is waiting and ready for test |
| rem_pat | input | N_CORES*CNT_W | Remaining pattern count, core i at bits [i*CNT_W +: CNT_W] |
| dweight | input | N_CORES*WGT_W | Defect-probability weight, core i at [i*WGT_W +: WGT_W] |
| temp | input | N_CORES*TEMP_W | Current temperature code, core i at [i*TEMP_W +: TEMP_W] |
| req_bw | input | N_CORES*BW_W | Bandwidth the core needs, core i at [i*BW_W +: BW_W] |
| bw_limit | input | BW_W | Total bus bandwidth available |
| alloc_go | input | 1 | Strobe that opens an allocation round when idle |
| core_stop | input | N_CORES | Core i has left testing and returns its bandwidth |
| grant | output | N_CORES | One-cycle grant pulse per core |
| free_bw | output | BW_W | Bandwidth not currently held |
| busy | output | 1 | Allocation round in progress |

## Verification
The bound checker watches four things on every cycle: that grants stay one-hot, that `free_bw` stays within the limit, that each grant debits exactly the winner's requirement, and that an already-holding core is never granted again. It also checks that a non-granting scan cycle closes the round and that releases from idle cores leave the pool untouched. The ordering rule itself can only be shown by the bench's scenarios, because it spans a whole round. The same holds for the stop-at-first-misfit rule with no skipping, the tie break toward the lower index and the exact round length. The bench compares each round's grant sequence against an arithmetic model, both on directed cases and on a long sweep of random readiness, keys, temperatures and requirements.

// File: rtl/bwa_pkg.sv
package bwa_pkg;

   // Round controller states
   typedef enum logic {
      RND_IDLE = 1'b0,
      RND_SCAN = 1'b1
   } rnd_state_e;

endpackage

// File: rtl/bwa_prio_pick.sv
// Picks the highest-ranked pending core by cross-multiplied comparison.
module bwa_prio_pick #(
   parameter int N_CORES = 4,
   parameter int KEY_W   = 12,
   parameter int TEMP_W  = 8,
   localparam int IW     = (N_CORES > 1) ? $clog2(N_CORES) : 1
) (
   input  logic [N_CORES-1:0]        pend,
   input  logic [N_CORES*KEY_W-1:0]  key_flat,
   input  logic [N_CORES*TEMP_W-1:0] temp_flat,
   output logic [IW-1:0]             best_idx,
   output logic                      best_vld
);

   localparam int XW = KEY_W + TEMP_W;

   logic [KEY_W-1:0]  key_a [N_CORES];
   logic [TEMP_W-1:0] tmp_a [N_CORES];

   for (genvar g = 0; g < N_CORES; g++) begin : g_unpack
      assign key_a[g] = key_flat[g*KEY_W +: KEY_W];
      assign tmp_a[g] = temp_flat[g*TEMP_W +: TEMP_W];
   end

   logic [KEY_W-1:0]  bk;
   logic [TEMP_W-1:0] bt;
   logic [XW-1:0]     lhs;
   logic [XW-1:0]     rhs;

   // Scan upward; replace only on strictly higher rank so ties keep lower index
   always_comb begin
      best_vld = 1'b0;
      best_idx = '0;
      bk       = '0;
      bt       = '0;
      lhs      = '0;
      rhs      = '0;
      for (int i = 0; i < N_CORES; i++) begin
         lhs = XW'(key_a[i]) * XW'(bt);
         rhs = XW'(bk) * XW'(tmp_a[i]);
         if (pend[i] && (!best_vld || (lhs > rhs))) begin
            best_vld = 1'b1;
            best_idx = IW'(i);
            bk       = key_a[i];
            bt       = tmp_a[i];
         end
      end
   end

endmodule

// File: rtl/bwa_ledger.sv
// Tracks which cores hold bandwidth, how much each holds, and the total in use.
module bwa_ledger #(
   parameter int N_CORES = 4,
   parameter int BW_W    = 5
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [N_CORES-1:0] grant_vec,
   input  logic [BW_W-1:0]    grant_amt,
   input  logic [N_CORES-1:0] core_stop,
   output logic [N_CORES-1:0] active,
   output logic [BW_W-1:0]    used
);

   localparam int AW = BW_W + $clog2(N_CORES) + 1;

   logic [N_CORES-1:0] act_q;
   logic [BW_W-1:0]    amt_q [N_CORES];
   logic [BW_W-1:0]    used_q;
   logic [AW-1:0]      ret_sum;
   logic [AW-1:0]      used_d;

   always_comb begin
      ret_sum = '0;
      for (int i = 0; i < N_CORES; i++) begin
         if (core_stop[i] && act_q[i]) ret_sum = ret_sum + AW'(amt_q[i]);
      end
      used_d = AW'(used_q) - ret_sum;
      if (|grant_vec) used_d = used_d + AW'(grant_amt);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         act_q  <= '0;
         used_q <= '0;
         for (int i = 0; i < N_CORES; i++) amt_q[i] <= '0;
      end else begin
         used_q <= BW_W'(used_d);
         for (int i = 0; i < N_CORES; i++) begin
            if (grant_vec[i]) begin
               act_q[i] <= 1'b1;
               amt_q[i] <= grant_amt;
            end else if (core_stop[i] && act_q[i]) begin
               act_q[i] <= 1'b0;
               amt_q[i] <= '0;
            end
         end
      end
   end

   assign active = act_q;
   assign used   = used_q;

endmodule

// File: rtl/bwa_round_ctl.sv
// Opens a round on the strobe, then grants one candidate per cycle until a stop.
module bwa_round_ctl
   import bwa_pkg::*;
#(
   parameter int N_CORES = 4,
   localparam int IW     = (N_CORES > 1) ? $clog2(N_CORES) : 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               alloc_go,
   input  logic [N_CORES-1:0] cand,
   input  logic [IW-1:0]      best_idx,
   input  logic               best_vld,
   input  logic               fit,
   input  logic               free_nz,
   output logic               busy,
   output logic [N_CORES-1:0] pend,
   output logic [N_CORES-1:0] grant_vec
);

   localparam logic [N_CORES-1:0] ONE = N_CORES'(1);

   rnd_state_e         state_q;
   logic [N_CORES-1:0] pend_q;
   logic               take;

   assign take      = (state_q == RND_SCAN) && best_vld && free_nz && fit;
   assign grant_vec = take ? (ONE << best_idx) : '0;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= RND_IDLE;
         pend_q  <= '0;
      end else begin
         unique case (state_q)
            RND_IDLE: begin
               if (alloc_go) begin
                  state_q <= RND_SCAN;
                  pend_q  <= cand;
               end
            end
            RND_SCAN: begin
               if (take) begin
                  pend_q <= pend_q & ~grant_vec;
               end else begin
                  state_q <= RND_IDLE;
                  pend_q  <= '0;
               end
            end
            default: state_q <= RND_IDLE;
         endcase
      end
   end

   assign busy = (state_q == RND_SCAN);
   assign pend = pend_q;

endmodule

// File: rtl/bw_grant_alloc.sv
// Top: priority-ordered test-bus bandwidth allocator.
module bw_grant_alloc #(
   parameter int N_CORES = 4,
   parameter int CNT_W   = 8,
   parameter int WGT_W   = 4,
   parameter int TEMP_W  = 8,
   parameter int BW_W    = 5
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic [N_CORES-1:0]        ready,
   input  logic [N_CORES*CNT_W-1:0]  rem_pat,
   input  logic [N_CORES*WGT_W-1:0]  dweight,
   input  logic [N_CORES*TEMP_W-1:0] temp,
   input  logic [N_CORES*BW_W-1:0]   req_bw,
   input  logic [BW_W-1:0]           bw_limit,
   input  logic                      alloc_go,
   input  logic [N_CORES-1:0]        core_stop,
   output logic [N_CORES-1:0]        grant,
   output logic [BW_W-1:0]           free_bw,
   output logic                      busy
);

   localparam int KEY_W = CNT_W + WGT_W;
   localparam int IW    = (N_CORES > 1) ? $clog2(N_CORES) : 1;

   // Elaboration-time parameter checks
   if (N_CORES < 2) begin : g_bad_ncores
      $error("bw_grant_alloc: N_CORES must be at least 2");
   end
   if (BW_W < 2) begin : g_bad_bw
      $error("bw_grant_alloc: BW_W must be at least 2");
   end
   if (CNT_W < 1 || WGT_W < 1 || TEMP_W < 1) begin : g_bad_key
      $error("bw_grant_alloc: key and temperature widths must be positive");
   end

   logic [N_CORES*KEY_W-1:0] key_flat;
   logic [BW_W-1:0]          req_a [N_CORES];

   // Per-core priority key: remaining patterns times defect weight
   for (genvar g = 0; g < N_CORES; g++) begin : g_key
      assign key_flat[g*KEY_W +: KEY_W] =
         KEY_W'(rem_pat[g*CNT_W +: CNT_W]) * KEY_W'(dweight[g*WGT_W +: WGT_W]);
      assign req_a[g] = req_bw[g*BW_W +: BW_W];
   end

   logic [N_CORES-1:0] act_mask;
   logic [N_CORES-1:0] pend;
   logic [N_CORES-1:0] grant_vec;
   logic [IW-1:0]      best_idx;
   logic               best_vld;
   logic [BW_W-1:0]    used;
   logic [BW_W-1:0]    take_amt;
   logic               fit;

   bwa_prio_pick #(
      .N_CORES (N_CORES),
      .KEY_W   (KEY_W),
      .TEMP_W  (TEMP_W)
   ) u_pick (
      .pend      (pend),
      .key_flat  (key_flat),
      .temp_flat (temp),
      .best_idx  (best_idx),
      .best_vld  (best_vld)
   );

   assign free_bw  = bw_limit - used;
   assign take_amt = req_a[best_idx];
   assign fit      = (take_amt <= free_bw);

   bwa_round_ctl #(
      .N_CORES (N_CORES)
   ) u_ctl (
      .clk       (clk),
      .rst_n     (rst_n),
      .alloc_go  (alloc_go),
      .cand      (ready & ~act_mask),
      .best_idx  (best_idx),
      .best_vld  (best_vld),
      .fit       (fit),
      .free_nz   (free_bw != '0),
      .busy      (busy),
      .pend      (pend),
      .grant_vec (grant_vec)
   );

   bwa_ledger #(
      .N_CORES (N_CORES),
      .BW_W    (BW_W)
   ) u_ledger (
      .clk       (clk),
      .rst_n     (rst_n),
      .grant_vec (grant_vec),
      .grant_amt (take_amt),
      .core_stop (core_stop),
      .active    (act_mask),
      .used      (used)
   );

   assign grant = grant_vec;

endmodule

// File: rtl/bw_grant_alloc_chk.sv
// Property checker bound to the allocator top.
module bw_grant_alloc_chk #(
   parameter int N_CORES = 4,
   parameter int BW_W    = 5
) (
   input logic               clk,
   input logic               rst_n,
   input logic               busy,
   input logic [N_CORES-1:0] grant,
   input logic [N_CORES-1:0] core_stop,
   input logic [N_CORES-1:0] act_mask,
   input logic [BW_W-1:0]    free_bw,
   input logic [BW_W-1:0]    bw_limit,
   input logic [BW_W-1:0]    take_amt
);

   // R10
   one_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(grant));

   // R7
   free_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      free_bw <= bw_limit);

   // R4
   grant_debit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((grant != '0) && (core_stop == '0)) |=>
         (($past(bw_limit) != bw_limit) || (free_bw == $past(free_bw) - $past(take_amt))));

   // R2
   no_regrant_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (grant & act_mask) == '0);

   // R6
   round_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && (grant == '0)) |=> !busy);

   // R8
   idle_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((grant == '0) && ((core_stop & act_mask) == '0)) |=>
         (($past(bw_limit) != bw_limit) || (free_bw == $past(free_bw))));

endmodule

bind bw_grant_alloc bw_grant_alloc_chk #(
   .N_CORES (N_CORES),
   .BW_W    (BW_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .busy      (busy),
   .grant     (grant),
   .core_stop (core_stop),
   .act_mask  (act_mask),
   .free_bw   (free_bw),
   .bw_limit  (bw_limit),
   .take_amt  (take_amt)
);

// File: tb/bw_grant_alloc_bench.sv
module bw_grant_alloc_bench;

   localparam int CLK_PERIOD = 10;
   localparam int NC         = 4;
   localparam int LIMIT      = 16;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [NC-1:0] ready = '0;
   logic [7:0]    rem [NC];
   logic [3:0]    wgt [NC];
   logic [7:0]    tmp [NC];
   logic [4:0]    req [NC];
   logic [31:0]   rem_flat;
   logic [15:0]   wgt_flat;
   logic [31:0]   tmp_flat;
   logic [19:0]   req_flat;
   logic          alloc_go = 1'b0;
   logic [NC-1:0] core_stop = '0;
   logic [NC-1:0] grant;
   logic [4:0]    free_bw;
   logic          busy;

   always #(CLK_PERIOD/2) clk = ~clk;

   always_comb begin
      for (int i = 0; i < NC; i++) begin
         rem_flat[i*8 +: 8] = rem[i];
         wgt_flat[i*4 +: 4] = wgt[i];
         tmp_flat[i*8 +: 8] = tmp[i];
         req_flat[i*5 +: 5] = req[i];
      end
   end

   bw_grant_alloc #(
      .N_CORES (NC), .CNT_W (8), .WGT_W (4), .TEMP_W (8), .BW_W (5)
   ) u_bw_grant_alloc (
      .clk (clk), .rst_n (rst_n), .ready (ready), .rem_pat (rem_flat),
      .dweight (wgt_flat), .temp (tmp_flat), .req_bw (req_flat),
      .bw_limit (5'(LIMIT)), .alloc_go (alloc_go), .core_stop (core_stop),
      .grant (grant), .free_bw (free_bw), .busy (busy)
   );

   int checks = 0;
   int errors = 0;
   int m_act [NC];
   int m_amt [NC];
   int m_used = 0;
   int cap [NC];
   int ncap = 0;
   bit done = 0;

   task automatic chk(input bit cond, input string rq, input int act, input int exp);
      checks++;
      if (!cond) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
      end
   endtask

   // Rank rule from R3: a above b when keyA*tempB > keyB*tempA, ties to lower index
   function automatic int model_pick(input bit [NC-1:0] pend);
      int best = -1;
      for (int j = 0; j < NC; j++) begin
         if (pend[j]) begin
            if (best < 0) best = j;
            else if (int'(rem[j]) * int'(wgt[j]) * int'(tmp[best]) >
                     int'(rem[best]) * int'(wgt[best]) * int'(tmp[j])) best = j;
         end
      end
      return best;
   endfunction

   task automatic set_core(input int i, input int r, input int w, input int t, input int b);
      rem[i] = 8'(r); wgt[i] = 4'(w); tmp[i] = 8'(t); req[i] = 5'(b);
   endtask

   // Runs one round, compares against the model, updates the model
   task automatic do_round(input string tag, input bit go_twice);
      int exp_seq [NC];
      int exp_n = 0;
      bit [NC-1:0] pend;
      int b;
      int cyc = 0;
      bit ok = 1;
      for (int j = 0; j < NC; j++) pend[j] = ready[j] && (m_act[j] == 0);
      while (pend != '0 && (LIMIT - m_used) > 0) begin
         b = model_pick(pend);
         if (int'(req[b]) > LIMIT - m_used) break;
         exp_seq[exp_n] = b;
         exp_n++;
         m_used += int'(req[b]);
         m_act[b] = 1;
         m_amt[b] = int'(req[b]);
         pend[b] = 1'b0;
      end
      ncap = 0;
      @(negedge clk); alloc_go = 1'b1;
      @(negedge clk); alloc_go = 1'b0;
      while (busy && cyc < 20) begin
         if ($countones(grant) > 1) ok = 0;
         if (grant != '0) begin
            for (int j = 0; j < NC; j++) begin
               if (grant[j] && ncap < NC) begin
                  cap[ncap] = j;
                  if (ncap >= exp_n || exp_seq[ncap] != j) ok = 0;
                  ncap++;
               end
            end
         end
         if (go_twice && cyc == 0) alloc_go = 1'b1;
         cyc++;
         @(negedge clk);
         alloc_go = 1'b0;
      end
      chk(ok && ncap == exp_n, {tag, " R3 grant sequence"}, ncap, exp_n);
      chk(cyc == exp_n + 1, {tag, " R6 round length"}, cyc, exp_n + 1);
      chk(int'(free_bw) == LIMIT - m_used, {tag, " R4 free after round"}, int'(free_bw), LIMIT - m_used);
      if (go_twice) begin
         @(negedge clk);
         chk(busy == 1'b0, {tag, " R9 strobe while busy ignored"}, int'(busy), 0);
      end
   endtask

   task automatic do_release(input bit [NC-1:0] m, input string tag);
      @(negedge clk); core_stop = m;
      @(negedge clk); core_stop = '0;
      for (int j = 0; j < NC; j++) begin
         if (m[j] && m_act[j] != 0) begin
            m_used -= m_amt[j];
            m_act[j] = 0;
            m_amt[j] = 0;
         end
      end
      chk(int'(free_bw) == LIMIT - m_used, {tag, " R8 free after release"}, int'(free_bw), LIMIT - m_used);
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      if (!done) begin
         errors++;
         $display("FAIL watchdog R6 actual=%0d expected=%0d", 1, 0);
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < NC; i++) begin
         set_core(i, 1, 1, 1, 1);
         m_act[i] = 0; m_amt[i] = 0;
      end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk(int'(free_bw) == LIMIT, "R1 free at reset", int'(free_bw), LIMIT);
      chk(busy == 1'b0, "R1 busy at reset", int'(busy), 0);
      chk(grant == '0, "R1 grant at reset", int'(grant), 0);

      // R3 ordering with tie: keys 10,30,20,30 at equal temperature -> 1,3,2,0
      set_core(0, 10, 1, 10, 2); set_core(1, 15, 2, 10, 2);
      set_core(2, 20, 1, 10, 2); set_core(3, 10, 3, 10, 2);
      ready = 4'b1111;
      do_round("order", 0);
      chk(cap[0] == 1 && cap[1] == 3 && cap[2] == 2 && cap[3] == 0,
          "R3 tie to lower index", cap[0] * 1000 + cap[1] * 100 + cap[2] * 10 + cap[3], 1320);
      do_release(4'b1111, "order");

      // R3 temperature lowers rank: core0 20/10 beats core1 30/20
      set_core(0, 20, 1, 10, 1); set_core(1, 30, 1, 20, 1);
      ready = 4'b0011;
      do_round("temp", 0);
      chk(cap[0] == 0, "R3 cooler core first", cap[0], 0);
      do_release(4'b0011, "temp");

      // R5 no skip: top needs 10, next 8 (misfit), last 2 would fit
      set_core(0, 90, 1, 10, 10); set_core(1, 50, 1, 10, 8);
      set_core(2, 10, 1, 10, 2);  set_core(3, 0, 0, 10, 1);
      ready = 4'b0111;
      do_round("noskip", 0);
      chk(ncap == 1 && cap[0] == 0, "R5 stop at first misfit", ncap, 1);
      chk(int'(free_bw) == 6, "R5 free after misfit", int'(free_bw), 6);

      // R2 holder and not-ready cores skipped: core0 holds, core3 not ready
      set_core(1, 50, 1, 10, 3);
      ready = 4'b0111;
      do_round("holder", 0);
      chk(ncap == 2 && cap[0] == 1 && cap[1] == 2, "R2 only ready idle cores", ncap, 2);

      // R8 release of a core holding nothing changes nothing
      do_release(4'b1000, "idle-stop");
      // R8 amount captured at grant is returned even after req changes
      req[0] = 5'd1;
      do_release(4'b0001, "captured");
      chk(int'(free_bw) == 11, "R8 captured amount returned", int'(free_bw), 11);
      do_release(4'b0110, "clear");

      // R6 exhaust to zero free, then an empty round of one cycle
      for (int i = 0; i < NC; i++) set_core(i, 5 + i, 1, 10, 4);
      ready = 4'b1111;
      do_round("fill", 0);
      chk(int'(free_bw) == 0, "R7 pool fully used", int'(free_bw), 0);
      do_round("empty", 0);
      chk(ncap == 0, "R6 no grant with zero free", ncap, 0);
      do_release(4'b1111, "fill");

      // R9 strobe while busy
      for (int i = 0; i < NC; i++) set_core(i, 3 * i + 1, 2, 20, 3);
      do_round("gotwice", 1);
      do_release(4'b1111, "gotwice");

      // Random sweep
      for (int n = 0; n < 400; n++) begin
         for (int i = 0; i < NC; i++)
            set_core(i, $urandom_range(255), $urandom_range(15),
                     $urandom_range(255, 1), $urandom_range(LIMIT, 1));
         ready = 4'($urandom_range(15));
         do_round("sweep", n % 7 == 3);
         do_release(4'($urandom_range(15)), "sweep");
      end

      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule